// File: doc/BRIEF.md
# Physical Region Pointer Scatter Walker

This block converts a data-transfer request into an ordered list of memory segments for a downstream DMA engine. A request carries a byte count, two 64-bit physical pointers and a memory-page-size code. The first pointer may begin anywhere inside a page. Any data left after that first page is described by the second pointer. If the remainder fits in one page, the second pointer is itself the data page. Otherwise it points to a table of 8-byte page pointers held in host memory.

The walker reads table entries one at a time through a simple request/response memory port. It emits one `(address, length)` segment per page on a valid/ready output. A full table page may end in a link to the next table page, and the walker follows these links. A zero or misaligned page pointer ends the walk. The block then raises both an invalid-field flag and a do-not-retry flag. It moves no data itself.

Top module: `prp_walker`

## Requirements
- R1: Page size is 2^(12+`mps`) bytes. The first segment has address `ptr1` and length min(`xfer_len`, page size − (`ptr1` mod page size)). No segment is zero-length or longer than one page.
- R2: A request with `ptr1` equal to zero produces no segment and ends with an error. A request with nonzero `ptr1` and `xfer_len` of zero produces no segment and ends without error.
- R3: If bytes remain after the first segment and `ptr2` is zero, the walk ends with an error after the first segment.
- R4: If the remainder after the first segment is at most one page, a second segment (`ptr2`, remainder) is emitted with no memory read. The segment is emitted only if `ptr2` is page-aligned; otherwise the walk ends with an error.
- R5: If the remainder exceeds one page, `ptr2` is the base of a pointer table. Entry i is read from `ptr2` + 8·i in ascending order, one read per data page. Within one table page this gives min(page/8, ceil(remainder/page)) reads.
- R6: A data entry that is zero or not page-aligned ends the walk with an error. No further segment is emitted and no further read is issued.
- R7: When the entry at slot page/8 − 1 is read while more than one page remains, that entry is the address of the next table page. Reading continues at slot 0 of that page. A zero or misaligned link ends the walk with an error.
- R8: Each segment built from a table entry has the entry as its address and min(remaining, page size) as its length.
- R9: `bad_field` and `no_retry` are both 1 on completion of a failed walk and both 0 on completion of a good one. They hold their value until the next `start`.
- R10: A segment holds its address and length until accepted with `seg_ready`. `done` pulses for one cycle only after the last segment has been accepted. `busy` is 0 in that cycle.
- R11: A read request holds `rd_req_addr` until `rd_req_ready`. The response word is the entry in little-endian byte order: the byte at the lowest address is in bits 7:0.
- R12: After reset, `busy`, `done`, `seg_valid`, `rd_req_valid`, `bad_field` and `no_retry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new request when idle |
| xfer_len | input | LEN_W | Total bytes to describe |
| ptr1 | input | 64 | First data pointer, any offset |
| ptr2 | input | 64 | Second data pointer or table base |
| mps | input | MPS_W | Page-size code, page = 2^(12+mps) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_field | output | 1 | Invalid-field status of last walk |
| no_retry | output | 1 | Do-not-retry status of last walk |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| rd_req_valid | output | 1 | Table-entry read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Byte address of the 8-byte entry |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Entry value, little-endian |

## Verification
The bench covers these cases:
- A first pointer sitting mid-page. A design that ignored the offset would overrun into the next page.
- A remainder of exactly one page or less. This must bypass the table. A design that confused the two paths would issue a spurious memory read or treat data as a table.
- A walk long enough to reach the last table slot. A walker that treated the link as data would emit a segment pointing at a table page. A link of zero must halt the walk.
- A bad entry in mid-walk, with back-pressure on both handshakes. These show whether segments leak out after the error, and whether a stalled output or read request changes its contents.

// File: rtl/prp_pkg.sv
package prp_pkg;

  typedef logic [63:0] addr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_DIRECT, S_FETCH, S_WAIT, S_EMIT, S_DRAIN
  } walk_st_t;

  // bytes in one memory page for a page-size code
  function automatic logic [63:0] page_bytes(input logic [3:0] code);
    return 64'd1 << (32'd12 + 32'(code));
  endfunction

  // bytes from a pointer up to the end of its page
  function automatic logic [63:0] room_in_page(input addr_t p, input logic [63:0] pg);
    return pg - (p & (pg - 64'd1));
  endfunction

  function automatic logic [63:0] min64(input logic [63:0] a, input logic [63:0] b);
    return (a < b) ? a : b;
  endfunction

  // a usable page pointer is nonzero and starts a page
  function automatic logic page_ok(input addr_t p, input logic [63:0] pg);
    return (p != 64'd0) && ((p & (pg - 64'd1)) == 64'd0);
  endfunction

endpackage

// File: rtl/prp_list_reader.sv
// Issues one table-entry read and returns the word (R11).
module prp_list_reader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [63:0] go_addr,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [63:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [63:0] rd_rsp_data,
  output logic        got,
  output logic [63:0] got_data
);
  typedef enum logic [1:0] {R_IDLE, R_REQ, R_RSP} rd_st_t;
  rd_st_t st;
  logic [63:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        R_IDLE: if (go) begin
          addr_q <= go_addr;
          st     <= R_REQ;
        end
        R_REQ:  if (rd_req_ready) st <= R_RSP;
        R_RSP:  if (rd_rsp_valid) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == R_REQ);
  assign rd_req_addr  = addr_q;
  assign got          = (st == R_RSP) && rd_rsp_valid;
  assign got_data     = rd_rsp_data;
endmodule

// File: rtl/prp_seg_slot.sv
// One-entry output register with valid/ready hold (R10).
module prp_seg_slot #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [63:0]      load_addr,
  input  logic [LEN_W-1:0] load_len,
  output logic             free,
  output logic             empty,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [63:0]      seg_addr,
  output logic [LEN_W-1:0] seg_len
);
  assign free  = !seg_valid || seg_ready;
  assign empty = !seg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_valid <= 1'b0;
      seg_addr  <= '0;
      seg_len   <= '0;
    end else if (load && free) begin
      seg_valid <= 1'b1;
      seg_addr  <= load_addr;
      seg_len   <= load_len;
    end else if (seg_ready) begin
      seg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prp_walker.sv
module prp_walker
  import prp_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int MPS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [63:0]      ptr1,
  input  logic [63:0]      ptr2,
  input  logic [MPS_W-1:0] mps,
  output logic             busy,
  output logic             done,
  output logic             bad_field,
  output logic             no_retry,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [63:0]      seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [63:0]      rd_req_addr,
  input  logic             rd_rsp_valid,
  input  logic [63:0]      rd_rsp_data
);
  // slots per table page reach 2^(9+max code)
  localparam int IDX_W = 9 + (1 << MPS_W) - 1;
  localparam int XW    = 64 - LEN_W;

  walk_st_t         st;
  logic [LEN_W-1:0] len_q, rem_q;
  logic [63:0]      p1_q, p2_q, base_q, ent_q;
  logic [MPS_W-1:0] mps_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q, bad_q;

  // named internal events, also watched by the checker
  logic             slot_free, slot_empty;
  logic             seg_load, load_is_list, error_hit, fetch_go;
  logic             got, entry_is_link;
  logic [63:0]      got_data, ld_addr, fetch_addr;
  logic [LEN_W-1:0] ld_len, first_len, rem_after_first, emit_len, pg_len;
  logic [63:0]      pg64, rem64, last_idx64;

  assign pg64            = page_bytes(4'(mps_q));
  assign pg_len          = LEN_W'(pg64);
  assign rem64           = {{XW{1'b0}}, rem_q};
  assign first_len       = LEN_W'(min64({{XW{1'b0}}, len_q}, room_in_page(p1_q, pg64)));
  assign rem_after_first = len_q - first_len;
  assign emit_len        = LEN_W'(min64(rem64, pg64));
  assign last_idx64      = (pg64 >> 3) - 64'd1;
  assign fetch_addr      = base_q + {{(64-IDX_W-3){1'b0}}, idx_q, 3'b000};
  // R7: last slot with more than a page left is a link
  assign entry_is_link   = ({{(64-IDX_W){1'b0}}, idx_q} == last_idx64) && (rem64 > pg64);

  always_comb begin
    seg_load     = 1'b0;
    load_is_list = 1'b0;
    ld_addr      = p1_q;
    ld_len       = first_len;
    fetch_go     = 1'b0;
    error_hit    = 1'b0;
    case (st)
      S_IDLE:  error_hit = start && (ptr1 == 64'd0);               // R2
      S_FIRST: if (len_q != '0 && slot_free) begin                 // R1
        seg_load  = 1'b1;
        error_hit = (rem_after_first != '0) && (p2_q == 64'd0);   // R3
      end
      S_DIRECT: begin                                              // R4
        load_is_list = 1'b1;
        ld_addr      = p2_q;
        ld_len       = rem_q;
        if (!page_ok(p2_q, pg64)) error_hit = 1'b1;
        else if (slot_free)       seg_load  = 1'b1;
      end
      S_FETCH: fetch_go = 1'b1;                                    // R5
      S_WAIT:  error_hit = got && !page_ok(got_data, pg64);        // R6, R7
      S_EMIT: begin                                                // R8
        load_is_list = 1'b1;
        ld_addr      = ent_q;
        ld_len       = emit_len;
        seg_load     = slot_free;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      len_q  <= '0;
      rem_q  <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
      base_q <= '0;
      ent_q  <= '0;
      mps_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          len_q <= xfer_len;
          p1_q  <= ptr1;
          p2_q  <= ptr2;
          mps_q <= mps;
          bad_q <= error_hit;                                      // R9
          st    <= error_hit ? S_DRAIN : S_FIRST;
        end
        S_FIRST: begin
          if (len_q == '0) st <= S_DRAIN;
          else if (slot_free) begin
            rem_q <= rem_after_first;
            if (rem_after_first == '0) st <= S_DRAIN;
            else if (error_hit) begin
              bad_q <= 1'b1;
              st    <= S_DRAIN;
            end else if (rem_after_first <= pg_len) st <= S_DIRECT;
            else begin
              base_q <= p2_q;
              idx_q  <= '0;
              st     <= S_FETCH;
            end
          end
        end
        S_DIRECT: begin
          if (error_hit) begin
            bad_q <= 1'b1;
            st    <= S_DRAIN;
          end else if (slot_free) begin
            rem_q <= '0;
            st    <= S_DRAIN;
          end
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (got) begin
          if (error_hit) begin
            bad_q <= 1'b1;
            st    <= S_DRAIN;
          end else if (entry_is_link) begin
            base_q <= got_data;
            idx_q  <= '0;
            st     <= S_FETCH;
          end else begin
            ent_q <= got_data;
            st    <= S_EMIT;
          end
        end
        S_EMIT: if (slot_free) begin
          rem_q <= rem_q - emit_len;
          idx_q <= idx_q + 1'b1;
          st    <= (rem_q == emit_len) ? S_DRAIN : S_FETCH;
        end
        S_DRAIN: if (slot_empty) begin                             // R10
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign bad_field = bad_q;
  assign no_retry  = bad_q;

  prp_list_reader u_rd (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .go_addr(fetch_addr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .got(got), .got_data(got_data)
  );

  prp_seg_slot #(.LEN_W(LEN_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(seg_load), .load_addr(ld_addr), .load_len(ld_len),
    .free(slot_free), .empty(slot_empty),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len)
  );
endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             bad_field,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [63:0]      seg_addr,
  input logic [LEN_W-1:0] seg_len,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [63:0]      rd_req_addr,
  input logic             seg_load,
  input logic             load_is_list,
  input logic [63:0]      ld_addr,
  input logic [LEN_W-1:0] pg_len
);
  p_seg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_quiet_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_field && !start |-> !seg_load && !rd_req_valid);

  p_page_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load && load_is_list |-> (ld_addr != 64'd0) &&
      ((ld_addr & ({{(64-LEN_W){1'b0}}, pg_len} - 64'd1)) == 64'd0));

  p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0) && (seg_len <= pg_len));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !seg_valid);
endmodule

bind prp_walker prp_walker_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bad_field(bad_field), .seg_valid(seg_valid), .seg_ready(seg_ready),
  .seg_addr(seg_addr), .seg_len(seg_len), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .seg_load(seg_load),
  .load_is_list(load_is_list), .ld_addr(ld_addr), .pg_len(pg_len)
);

// File: tb/test_prp_walker.sv
module test_prp_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] xfer_len = '0;
  logic [63:0] ptr1 = '0, ptr2 = '0;
  logic [3:0]  mps = '0;
  logic        busy, done, bad_field, no_retry;
  logic        seg_valid, seg_ready = 1'b1;
  logic [63:0] seg_addr;
  logic [31:0] seg_len;
  logic        rd_req_valid, rd_req_ready = 1'b1;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;

  always #2.5 clk = ~clk;

  prp_walker i_prp_walker (.*);

  int total = 0, fails = 0;
  bit bp = 1'b0;
  int cyc = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] got_addr[$], got_len[$], got_rd[$];
  logic [63:0] exp_addr[$], exp_len[$], exp_rd[$];
  bit exp_err;

  // inputs driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    seg_ready    <= bp ? cyc[0] : 1'b1;
    rd_req_ready <= bp ? cyc[1] : 1'b1;
  end

  // memory model and sinks
  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem.exists(rd_req_addr) ? mem[rd_req_addr] : 64'd0;
      got_rd.push_back(rd_req_addr);
    end
    if (seg_valid && seg_ready) begin
      got_addr.push_back(seg_addr);
      got_len.push_back({32'd0, seg_len});
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // bench model of the walk, stated from the requirements
  function automatic logic [63:0] peek(input logic [63:0] a);
    exp_rd.push_back(a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic bit good_ptr(input logic [63:0] p, input logic [63:0] pg);
    return p != 0 && (p % pg) == 0;
  endfunction

  task automatic model(input logic [31:0] len, input logic [63:0] p1, p2, input logic [3:0] m);
    logic [63:0] pg, rem, base, e, take;
    int slot;
    exp_addr.delete(); exp_len.delete(); exp_rd.delete(); exp_err = 0;
    pg = 64'd4096 << m;
    if (p1 == 0) begin exp_err = 1; return; end
    if (len == 0) return;
    take = (len < pg - (p1 % pg)) ? len : pg - (p1 % pg);
    exp_addr.push_back(p1); exp_len.push_back(take);
    rem = len - take;
    if (rem == 0) return;
    if (p2 == 0) begin exp_err = 1; return; end
    if (rem <= pg) begin
      if (!good_ptr(p2, pg)) exp_err = 1;
      else begin exp_addr.push_back(p2); exp_len.push_back(rem); end
      return;
    end
    base = p2; slot = 0;
    while (rem != 0) begin
      e = peek(base + 8 * slot);
      if (slot == pg / 8 - 1 && rem > pg) begin
        if (!good_ptr(e, pg)) begin exp_err = 1; return; end
        base = e; slot = 0;
        e = peek(base);
      end
      if (!good_ptr(e, pg)) begin exp_err = 1; return; end
      take = (rem < pg) ? rem : pg;
      exp_addr.push_back(e); exp_len.push_back(take);
      rem -= take; slot++;
    end
  endtask

  task automatic run(input logic [31:0] len, input logic [63:0] p1, p2, input logic [3:0] m,
                     input string tag);
    int n = 0;
    got_addr.delete(); got_len.delete(); got_rd.delete();
    model(len, p1, p2, m);
    @(negedge clk);
    xfer_len = len; ptr1 = p1; ptr2 = p2; mps = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    chk(done, tag, "done pulse", {63'd0, done}, 64'd1);
    chk(!busy, "R10", "busy at done", {63'd0, busy}, 64'd0);
    chk(bad_field == exp_err, "R9", {tag, " bad_field"}, {63'd0, bad_field}, {63'd0, exp_err});
    chk(no_retry == exp_err, "R9", {tag, " no_retry"}, {63'd0, no_retry}, {63'd0, exp_err});
    chk(got_addr.size() == exp_addr.size(), tag, "segment count",
        got_addr.size(), exp_addr.size());
    for (int k = 0; k < got_addr.size() && k < exp_addr.size(); k++)
      if (got_addr[k] != exp_addr[k] || got_len[k] != exp_len[k]) begin
        chk(0, tag, $sformatf("segment %0d addr", k), got_addr[k], exp_addr[k]);
        chk(0, tag, $sformatf("segment %0d len", k), got_len[k], exp_len[k]);
        break;
      end
    chk(got_rd.size() == exp_rd.size(), tag, "read count", got_rd.size(), exp_rd.size());
    for (int k = 0; k < got_rd.size() && k < exp_rd.size(); k++)
      if (got_rd[k] != exp_rd[k]) begin
        chk(0, tag, $sformatf("read %0d addr", k), got_rd[k], exp_rd[k]);
        break;
      end
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R12", "busy/done after reset", {62'd0, busy, done}, 64'd0);
    chk(!seg_valid && !rd_req_valid, "R12", "valids after reset",
        {62'd0, seg_valid, rd_req_valid}, 64'd0);
    chk(!bad_field && !no_retry, "R12", "flags after reset", {62'd0, bad_field, no_retry}, 64'd0);
  endtask

  task automatic t_single_page;   // R1: fits in the first page
    run(32'd512, 64'h1000_0100, 64'd0, 4'd0, "R1");
  endtask

  task automatic t_direct;        // R4: offset first page then direct second
    run(32'h1000, 64'h1000_0800, 64'h2000_0000, 4'd0, "R4");
    run(32'h1000, 64'h1000_0800, 64'h2000_0010, 4'd0, "R4");   // misaligned second
  endtask

  task automatic t_zero_cases;    // R2 and R3
    run(32'd4096, 64'd0, 64'h2000_0000, 4'd0, "R2");
    run(32'd0, 64'h1000_0000, 64'd0, 4'd0, "R2");
    run(32'h1800, 64'h1000_0000, 64'd0, 4'd0, "R3");
  endtask

  task automatic t_list_bp;       // R5, R8, R10, R11 with back-pressure, 8 KiB pages
    for (int k = 0; k < 3; k++) mem[64'h3000_0008 + 8 * k] = 64'h7_0000_0000 + 64'h2000 * (k + 1);
    bp = 1'b1;
    run(32'h2000 * 3 + 32'd100, 64'h5000_0000, 64'h3000_0008, 4'd1, "R5");
    bp = 1'b0;
  endtask

  task automatic t_bad_entry;     // R6: second entry misaligned
    mem[64'h3100_0000] = 64'h8_0000_0000;
    mem[64'h3100_0008] = 64'h8_0000_0040;
    mem[64'h3100_0010] = 64'h8_0000_2000;
    run(32'h1000 * 4, 64'h6000_0000, 64'h3100_0000, 4'd0, "R6");
  endtask

  task automatic t_chain;         // R7: link in last slot of a 4 KiB table page
    for (int k = 0; k < 511; k++) begin
      mem[64'h4000_0000 + 8 * k] = 64'h1_0000_0000 + 64'h1000 * k;
      mem[64'h6000_0000 + 8 * k] = 64'h1_0000_0000 + 64'h1000 * k;
    end
    mem[64'h4000_0000 + 8 * 511] = 64'h5000_0000;
    for (int k = 0; k < 8; k++) mem[64'h5000_0000 + 8 * k] = 64'h2_0000_0000 + 64'h1000 * k;
    run(32'h1000 * 519 + 32'd256, 64'h0800_0000, 64'h4000_0000, 4'd0, "R7");
    run(32'h1000 * 519 + 32'd256, 64'h0800_0000, 64'h6000_0000, 4'd0, "R7");   // null link
  endtask

  task automatic t_big_page;      // R1 with 64 KiB pages, then R9 flags clear after an error
    run(32'h2_0000, 64'h1234_4000, 64'h4_0000_0000, 4'd4, "R1");
    run(32'd64, 64'd0, 64'd0, 4'd0, "R9");
    run(32'd64, 64'h10, 64'd0, 4'd0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_page();
    t_direct();
    t_zero_cases();
    t_list_bp();
    t_bad_entry();
    t_chain();
    t_big_page();
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule